// File: doc/BRIEF.md
# Strobe-Restarted Watchdog with Three-Way Timeout Select

This block supervises software through a single strobe pin. Once the system reset goes inactive, it counts millisecond ticks. Every high-to-low transition on the strobe restarts the count. If the strobe stops, the count reaches the selected limit. The block then raises a reset request of fixed length, and after that it arms itself again.

The timeout is picked by a 2-bit code. The code comes from a pin that was strapped low, left open or strapped high, and that pin has already been resolved to the code outside this block. The code is captured at the moment the system reset releases. The watchdog does nothing while the system reset is active. A status output shows when the timer is counting.

Time is measured in ticks of `CLKS_PER_TICK` clock cycles each. Below, T stands for the tick count of the selected timeout, K for `CLKS_PER_TICK` and P for `PULSE_TICKS`.

Top module: `strobe_watchdog`

## Requirements
- R1: The select code maps to a timeout as follows: 2'b00 gives TICKS_LOW (150), 2'b01 gives TICKS_FLOAT (600), 2'b10 gives TICKS_HIGH (1200), and 2'b11 is treated like 2'b01. Counting with no strobe edge, `wdt_rst_o` rises on clock edge 1+T*K, counted from the first edge that samples `sys_rst_i` low.
- R2: While `sys_rst_i` is high, no count advances and `armed_o` is low. A count that is already in progress is abandoned, and a later release starts a fresh full timeout.
- R3: A falling edge on `strobe_i` passes through two synchronizer flops and one edge register. It clears the count on the third clock edge after the pin changes, and the next expiry follows T*K edges after that clearing edge.
- R4: Rising edges and steady levels on `strobe_i` do not restart or delay the count.
- R5: On expiry, `wdt_rst_o` stays high for exactly P*K clock cycles (P defaults to 250).
- R6: When the pulse ends, the block waits until `sys_rst_i` is low before counting again. If `sys_rst_i` is already low, the next expiry comes 1+T*K edges after the edge on which `wdt_rst_o` fell.
- R7: The select code is captured on the edge that leaves reset. Changing `tsel_i` while counting has no effect on the running timeout.
- R8: A strobe falling edge that takes effect on the same edge as expiry does not cancel the reset pulse. The same edge one cycle earlier restarts the count.
- R9: While `rst_n` is low, `wdt_rst_o` and `armed_o` are both low.
- R10: `armed_o` is high exactly while the timer counts. It goes high on the edge after `sys_rst_i` is first sampled low, and it is low during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| sys_rst_i | input | 1 | System reset active (high); holds the watchdog idle |
| strobe_i | input | 1 | Software strobe, asynchronous; falling edge restarts |
| tsel_i | input | 2 | Timeout select code |
| wdt_rst_o | output | 1 | Reset request pulse on expiry |
| armed_o | output | 1 | Timer is counting |

## Verification
Expiry and a strobe restart can land on the same clock edge. Expiry must win that collision. The bench provokes the collision by counting edges from the release of the system reset. It drives the strobe low exactly three edges before the expiry edge and requires the pulse to appear on time. It then repeats the test with the strobe one cycle earlier. In that case no pulse may appear, and the next expiry must fall a full timeout after the restart.

// File: rtl/strobe_wdt_pkg.sv
package strobe_wdt_pkg;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_COUNT = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_e;

  localparam logic [1:0] SEL_LOW  = 2'b00;
  localparam logic [1:0] SEL_OPEN = 2'b01;
  localparam logic [1:0] SEL_HIGH = 2'b10;

  // Timeout in ticks for a select code; 2'b11 falls back to the open value.
  function automatic int unsigned sel_ticks(input logic [1:0] sel,
                                            input int unsigned t_low,
                                            input int unsigned t_open,
                                            input int unsigned t_high);
    case (sel)
      SEL_LOW:  return t_low;
      SEL_HIGH: return t_high;
      default:  return t_open;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Bits needed to hold values 0..maxval, never less than one.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return ($clog2(maxval + 1) < 1) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned CLKS_PER_TICK = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  import strobe_wdt_pkg::*;

  localparam int unsigned DW = cnt_width(CLKS_PER_TICK - 1);

  logic [DW-1:0] pre_q;

  assign tick_o = (pre_q == DW'(CLKS_PER_TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clr_i || tick_o)  pre_q <= '0;
    else                       pre_q <= pre_q + DW'(1);
  end

  generate
    if (CLKS_PER_TICK > 1) begin : g_spacing
      // Ticks are separated by at least one idle cycle (timing base of R1)
      p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/wdt_strobe_edge.sv
module wdt_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  // Stages 0..SYNC_STAGES-1 synchronize; the last stage holds the previous level.
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], strobe_i};
  end

  assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

  // A detected falling edge is a single-cycle event (R3)
  p_fall_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CLKS_PER_TICK = 50000,
  parameter int unsigned TICKS_LOW     = 150,
  parameter int unsigned TICKS_FLOAT   = 600,
  parameter int unsigned TICKS_HIGH    = 1200,
  parameter int unsigned PULSE_TICKS   = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst_i,
  input  logic [1:0] tsel_i,
  input  logic       tick_i,
  input  logic       fall_i,
  output logic       tick_clr_o,
  output logic       rst_req_o,
  output logic       armed_o
);
  import strobe_wdt_pkg::*;

  localparam int unsigned TMAX = max3(TICKS_LOW, TICKS_FLOAT, TICKS_HIGH);
  localparam int unsigned CW   = cnt_width(TMAX);
  localparam int unsigned PW   = cnt_width(PULSE_TICKS);

  wd_state_e      state_q;
  logic [CW-1:0]  limit_q;
  logic [CW-1:0]  cnt_q;
  logic [PW-1:0]  pcnt_q;

  // Named events for the assertions
  logic counting_w;
  logic expire_w;
  logic restart_w;
  logic pulse_done_w;
  logic release_w;

  assign counting_w   = (state_q == WD_COUNT) && !sys_rst_i;
  assign expire_w     = counting_w && tick_i && (cnt_q == (limit_q - CW'(1)));
  assign restart_w    = counting_w && fall_i && !expire_w;
  assign pulse_done_w = (state_q == WD_PULSE) && tick_i &&
                        (pcnt_q == PW'(PULSE_TICKS - 1));
  assign release_w    = (state_q == WD_IDLE) && !sys_rst_i;

  assign tick_clr_o = (state_q == WD_IDLE) || restart_w || expire_w;
  assign rst_req_o  = (state_q == WD_PULSE);
  assign armed_o    = (state_q == WD_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      limit_q <= '0;
      cnt_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          cnt_q <= '0;
          if (release_w) begin
            state_q <= WD_COUNT;
            limit_q <= CW'(sel_ticks(tsel_i, TICKS_LOW, TICKS_FLOAT, TICKS_HIGH));
          end
        end
        WD_COUNT: begin
          if (sys_rst_i) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
          end else if (expire_w) begin
            state_q <= WD_PULSE;
            pcnt_q  <= '0;
            cnt_q   <= '0;
          end else if (restart_w) begin
            cnt_q <= '0;
          end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        WD_PULSE: begin
          if (pulse_done_w)  state_q <= WD_IDLE;
          else if (tick_i)   pcnt_q  <= pcnt_q + PW'(1);
        end
        default: state_q <= WD_IDLE;
      endcase
    end
  end

  // Checker counter for the pulse length, kept beside the logic it guards
  int unsigned pulse_cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pulse_cyc_q <= 0;
    else if (state_q == WD_PULSE) pulse_cyc_q <= pulse_cyc_q + 1;
    else                          pulse_cyc_q <= 0;
  end

  p_idle_in_sysrst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && !rst_req_o) |=> !armed_o);

  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> (cnt_q == '0) && armed_o);

  p_tick_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (counting_w && tick_i && !fall_i && !expire_w) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  p_pulse_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> (pulse_cyc_q == PULSE_TICKS * CLKS_PER_TICK));

  p_pulse_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> !armed_o);

  p_limit_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_COUNT) |=> ((state_q != WD_COUNT) || $stable(limit_q)));

  p_expiry_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && fall_i) |=> rst_req_o);

  p_arm_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(!sys_rst_i));

  p_outputs_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_o && rst_req_o));

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned CLKS_PER_TICK = 50000,
  parameter int unsigned TICKS_LOW     = 150,
  parameter int unsigned TICKS_FLOAT   = 600,
  parameter int unsigned TICKS_HIGH    = 1200,
  parameter int unsigned PULSE_TICKS   = 250,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst_i,
  input  logic       strobe_i,
  input  logic [1:0] tsel_i,
  output logic       wdt_rst_o,
  output logic       armed_o
);

  logic tick_w;
  logic tick_clr_w;
  logic fall_w;

  wdt_tick_gen #(
    .CLKS_PER_TICK(CLKS_PER_TICK)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tick_clr_w),
    .tick_o (tick_w)
  );

  wdt_strobe_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .fall_o   (fall_w)
  );

  wdt_core #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .TICKS_LOW    (TICKS_LOW),
    .TICKS_FLOAT  (TICKS_FLOAT),
    .TICKS_HIGH   (TICKS_HIGH),
    .PULSE_TICKS  (PULSE_TICKS)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst_i  (sys_rst_i),
    .tsel_i     (tsel_i),
    .tick_i     (tick_w),
    .fall_i     (fall_w),
    .tick_clr_o (tick_clr_w),
    .rst_req_o  (wdt_rst_o),
    .armed_o    (armed_o)
  );

  // Reset values at the ports (R9)
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r9: assert (!wdt_rst_o && !armed_o);
    end
  end

endmodule

// File: tb/test_strobe_watchdog.sv
module test_strobe_watchdog;

  localparam int K  = 2;
  localparam int TL = 15;
  localparam int TF = 60;
  localparam int TH = 120;
  localparam int P  = 25;
  localparam int LIM = 2000;

  localparam int NV = 4;
  localparam logic [1:0] V_SEL   [NV] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         V_TICKS [NV] = '{TL, TF, TH, TF};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_rst = 1'b1;
  logic       strobe = 1'b1;
  logic [1:0] tsel = 2'b00;
  logic       wdt_rst;
  logic       armed;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  strobe_watchdog #(
    .CLKS_PER_TICK(K), .TICKS_LOW(TL), .TICKS_FLOAT(TF),
    .TICKS_HIGH(TH), .PULSE_TICKS(P), .SYNC_STAGES(2)
  ) i_strobe_watchdog (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst), .strobe_i(strobe),
    .tsel_i(tsel), .wdt_rst_o(wdt_rst), .armed_o(armed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_high(output int n);
    n = 0;
    do begin step(); n++; end while (!wdt_rst && n < LIM);
  endtask

  task automatic wait_low(output int n);
    n = 0;
    do begin step(); n++; end while (wdt_rst && n < LIM);
  endtask

  task automatic settle();
    int n;
    sys_rst = 1'b1;
    strobe  = 1'b1;
    wait_low(n);
    repeat (4) step();
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int n;
    int hi;
    int seen;
    @(negedge clk);
    repeat (3) step();
    // R9: reset state
    chk(!wdt_rst && !armed, "R9", {wdt_rst, armed}, 0);
    rst_n = 1'b1;

    // R2: idle while system reset is held, strobe activity ignored
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      strobe = (i % 6) < 3;
      step();
      hi += wdt_rst | armed;
    end
    strobe = 1'b1;
    chk(hi == 0, "R2", hi, 0);

    // Vector table: timeout per code, pulse width, re-arm
    for (int v = 0; v < NV; v++) begin
      settle();
      tsel = V_SEL[v];
      step();
      sys_rst = 1'b0;
      step();
      // R10: armed on the edge after release
      chk(armed == 1'b1, "R10", armed, 1);
      wait_high(n);
      chk(n + 1 == 1 + V_TICKS[v] * K, "R1", n + 1, 1 + V_TICKS[v] * K);
      chk(armed == 1'b0, "R10", armed, 0);
      wait_low(n);
      chk(n == P * K, "R5", n, P * K);
      wait_high(n);
      chk(n == 1 + V_TICKS[v] * K, "R6", n, 1 + V_TICKS[v] * K);
    end

    // R3: regular strobes keep the reset away; last one sets the expiry point
    settle();
    tsel = 2'b00;
    sys_rst = 1'b0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      strobe = 1'b0;
      repeat (4) begin step(); seen += wdt_rst; end
      strobe = 1'b1;
      repeat (16) begin step(); seen += wdt_rst; end
    end
    chk(seen == 0, "R3", seen, 0);
    strobe = 1'b0;
    wait_high(n);
    chk(n == 3 + TL * K, "R3", n, 3 + TL * K);

    // R4: rising edge and static low do not restart
    settle();
    strobe = 1'b0;
    repeat (10) step();
    sys_rst = 1'b0;
    n = 0;
    do begin
      step();
      n++;
      if (n == 10) strobe = 1'b1;
    end while (!wdt_rst && n < LIM);
    chk(n == 1 + TL * K, "R4", n, 1 + TL * K);

    // R7: select change mid-count has no effect
    settle();
    tsel = 2'b00;
    sys_rst = 1'b0;
    n = 0;
    do begin
      step();
      n++;
      if (n == 5) tsel = 2'b10;
    end while (!wdt_rst && n < LIM);
    chk(n == 1 + TL * K, "R7", n, 1 + TL * K);

    // R8: strobe landing on the expiry edge does not cancel the pulse
    settle();
    tsel = 2'b00;
    sys_rst = 1'b0;
    n = 0;
    do begin
      step();
      n++;
      if (n == TL * K - 2) strobe = 1'b0;
    end while (!wdt_rst && n < LIM);
    chk(n == 1 + TL * K, "R8", n, 1 + TL * K);

    // R8: one cycle earlier it restarts instead
    settle();
    tsel = 2'b00;
    sys_rst = 1'b0;
    n = 0;
    do begin
      step();
      n++;
      if (n == TL * K - 3) strobe = 1'b0;
    end while (!wdt_rst && n < LIM);
    chk(n == 2 * TL * K, "R8", n, 2 * TL * K);

    // R6: pulse ending while system reset is held waits for release
    sys_rst = 1'b1;
    wait_low(n);
    hi = 0;
    repeat (100) begin step(); hi += wdt_rst | armed; end
    chk(hi == 0, "R6", hi, 0);
    strobe = 1'b1;
    sys_rst = 1'b0;
    wait_high(n);
    chk(n == 1 + TL * K, "R6", n, 1 + TL * K);

    // R2: system reset mid-count abandons the count
    settle();
    tsel = 2'b01;
    sys_rst = 1'b0;
    repeat (20) step();
    sys_rst = 1'b1;
    repeat (5) step();
    chk(armed == 1'b0 && wdt_rst == 1'b0, "R2", {armed, wdt_rst}, 0);
    sys_rst = 1'b0;
    wait_high(n);
    chk(n == 1 + TF * K, "R2", n, 1 + TF * K);

    settle();
    report();
  end

endmodule